// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block is a timer run as two independent 8-bit counters, a low half and a high half. Each half counts enable pulses from its own clock choice. A half set to fast mode counts on every system clock. A half set to slow mode counts pulses from a source chosen by a 2-bit select field, and both halves share that field. The select field offers four codes: the system clock divided by 12, rising edges of a comparator input, every eighth rising edge of an external clock input, and a reserved code that gives no pulses. When a half passes 0xFF, it loads its own reload value and sets its own sticky overflow flag.

The two flags drive one level-sensitive interrupt request. A low-half overflow also drives a one-cycle trigger pulse toward an ADC. Software programs the block through a small write port with four addresses: control, flag clear, low reload and high reload. The counters and flags are visible as outputs. All prescaling uses enable pulses in the system clock domain. The asynchronous comparator and external clock inputs are synchronised before their edges are detected.

Top module: `split_timer8x2`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, both counters, both flags, irq and adc_trig are 0 until counting starts.
- R2: A write to address 0 sets the control bits: bit0 run, bit1 irq enable, bit2 low-flag irq enable, bit3 low-half fast mode, bit4 high-half fast mode, bits[6:5] source select. A half in fast mode increments once per system clock while run is 1.
- R3: A slow-mode half with select 00 increments once every 12 clocks. The divider starts at reset release, so its pulse is consumed on the 12th, 24th and later edges after release.
- R4: With select 01, a slow-mode half increments once per rising edge of cmp_in. The count appears within four clocks of the edge.
- R5: With select 10, a slow-mode half increments once per eight rising edges of ext_clk_in.
- R6: With select 11, a slow-mode half never changes.
- R7: When a counter at 0xFF receives a count pulse, it loads its reload value. The low reload is at address 2 and the high reload is at address 3. Reset sets both reload values to 0x00.
- R8: A wrap sets the half's flag. The flag stays set until a write to address 1 with data bit0 (low) or bit1 (high) equal to 1. If a wrap and a clear happen in the same cycle, the flag stays set.
- R9: irq = irq_en AND (flag_hi OR (low_irq_en AND flag_lo)).
- R10: While run is 0, neither counter changes.
- R11: adc_trig is high for the one cycle after each low-half wrap, which is the cycle in which cnt_lo shows the reloaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Asynchronous comparator output |
| ext_clk_in | input | 1 | Asynchronous external clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| cnt_lo | output | 8 | Low counter value |
| cnt_hi | output | 8 | High counter value |
| flag_lo | output | 1 | Low overflow flag |
| flag_hi | output | 1 | High overflow flag |
| irq | output | 1 | Interrupt request, level |
| adc_trig | output | 1 | Low-overflow pulse for the ADC |

## Verification
The checker tests on every cycle that the counters hold while stopped or on the reserved select code, and that a fast-mode half steps by one. It also checks that the flags only drop after a clear write, that irq never rises without a flag, and that adc_trig coincides with the reload value. Only the bench scenarios can show the exact divide ratios, the count-per-edge behaviour after synchronisation, the wrap points with different reload values, and the case where a set and a clear land in the same cycle.

// File: rtl/stm_pkg.sv
// Package: shared constants for the split dual 8-bit timer.
// Assumes: register addresses and control bit positions are fixed by the
// software interface described in the brief.
package stm_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_FCLR  = 2'd1;
    localparam logic [ADDR_W-1:0] A_RLLO  = 2'd2;
    localparam logic [ADDR_W-1:0] A_RLHI  = 2'd3;
    localparam int B_RUN    = 0;
    localparam int B_IRQEN  = 1;
    localparam int B_LOIEN  = 2;
    localparam int B_LOSYS  = 3;
    localparam int B_HISYS  = 4;
    localparam int B_SEL    = 5;

    typedef enum logic [1:0] {
        SRC_DIV12 = 2'b00,
        SRC_CMP   = 2'b01,
        SRC_EXT8  = 2'b10,
        SRC_NONE  = 2'b11
    } src_sel_e;
endpackage

// File: rtl/stm_prescale.sv
// Module: stm_prescale
// Counts advance pulses and emits a one-cycle tick on every DIV-th one.
// Assumes: DIV >= 2; counter restarts from zero on reset.
module stm_prescale #(
    parameter int DIV = 12,
    localparam int CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tick
);
    logic [CW-1:0] cnt;

    assign tick = adv && (cnt == CW'(DIV - 1));

    // Purpose: free-running modulo-DIV counter advanced by adv.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (tick)    cnt <= '0;
        else if (adv)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/stm_edge_sync.sv
// Module: stm_edge_sync
// Two-flop synchroniser followed by a rising-edge detector.
// Assumes: input pulses last at least two system clocks in each level.
module stm_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic s1, s2, prev;

    assign rise = s2 && !prev;

    // Purpose: bring async_in into the clock domain and keep last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            prev <= 1'b0;
        end else begin
            s1   <= async_in;
            s2   <= s1;
            prev <= s2;
        end
    end
endmodule

// File: rtl/stm_half.sv
// Module: stm_half
// One 8-bit auto-reload counter half with a sticky overflow flag.
// Assumes: tick already includes the run gate; clr is a one-cycle strobe.
module stm_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] reload,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic         flag
);
    assign ovf = tick && (cnt == {W{1'b1}});

    // Purpose: count ticks, reloading on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (ovf)    cnt <= reload;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    // Purpose: sticky flag, set has priority over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else             flag <= ovf | (flag & ~clr);
    end
endmodule

// File: rtl/split_timer8x2.sv
// Module: split_timer8x2
// Two independent 8-bit auto-reload counters with per-half clock choice,
// sticky flags, a combined level interrupt and an ADC trigger strobe.
// Assumes: single clock domain; cmp_in and ext_clk_in are asynchronous.
module split_timer8x2
    import stm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_in,
    input  logic              ext_clk_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cnt_lo,
    output logic [DATA_W-1:0] cnt_hi,
    output logic              flag_lo,
    output logic              flag_hi,
    output logic              irq,
    output logic              adc_trig
);
    localparam int NH = 2;

    logic              run, irq_en, lo_irq_en, lo_sys, hi_sys;
    src_sel_e          xsel;
    logic [DATA_W-1:0] rl_lo, rl_hi;
    logic              div12_tick, cmp_rise, ext_rise, ext8_tick, src_tick;
    logic [NH-1:0]     fast, tick_h, clr_h, ovf_h, flag_h;
    logic [DATA_W-1:0] rl_h  [NH];
    logic [DATA_W-1:0] cnt_h [NH];

    // Purpose: control and reload register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; irq_en <= 1'b0; lo_irq_en <= 1'b0;
            lo_sys <= 1'b0; hi_sys <= 1'b0; xsel <= SRC_DIV12;
            rl_lo <= '0; rl_hi <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    run       <= wr_data[B_RUN];
                    irq_en    <= wr_data[B_IRQEN];
                    lo_irq_en <= wr_data[B_LOIEN];
                    lo_sys    <= wr_data[B_LOSYS];
                    hi_sys    <= wr_data[B_HISYS];
                    xsel      <= src_sel_e'(wr_data[B_SEL +: 2]);
                end
                A_RLLO:  rl_lo <= wr_data;
                A_RLHI:  rl_hi <= wr_data;
                default: ;
            endcase
        end
    end

    stm_prescale #(.DIV(12)) u_div12 (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .tick(div12_tick));
    stm_edge_sync u_cmp_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise(cmp_rise));
    stm_edge_sync u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in), .rise(ext_rise));
    stm_prescale #(.DIV(8)) u_div8 (
        .clk(clk), .rst_n(rst_n), .adv(ext_rise), .tick(ext8_tick));

    // Purpose: shared slow-source multiplexer.
    always_comb begin
        case (xsel)
            SRC_DIV12: src_tick = div12_tick;
            SRC_CMP:   src_tick = cmp_rise;
            SRC_EXT8:  src_tick = ext8_tick;
            default:   src_tick = 1'b0;
        endcase
    end

    assign fast     = {hi_sys, lo_sys};
    assign rl_h[0]  = rl_lo;
    assign rl_h[1]  = rl_hi;

    for (genvar h = 0; h < NH; h++) begin : g_half
        assign tick_h[h] = run && (fast[h] || src_tick);
        assign clr_h[h]  = wr_en && (wr_addr == A_FCLR) && wr_data[h];
        stm_half #(.W(DATA_W)) u_half (
            .clk(clk), .rst_n(rst_n), .tick(tick_h[h]), .reload(rl_h[h]),
            .clr(clr_h[h]), .cnt(cnt_h[h]), .ovf(ovf_h[h]), .flag(flag_h[h]));
    end

    // Purpose: register the low overflow as the ADC trigger strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) adc_trig <= 1'b0;
        else        adc_trig <= ovf_h[0];
    end

    assign cnt_lo  = cnt_h[0];
    assign cnt_hi  = cnt_h[1];
    assign flag_lo = flag_h[0];
    assign flag_hi = flag_h[1];
    assign irq     = irq_en && (flag_hi || (lo_irq_en && flag_lo));
endmodule

// File: rtl/stm_checker.sv
// Module: stm_checker
// Cycle-by-cycle properties of split_timer8x2, attached by bind.
// Assumes: sees the top's ports and its control/reload registers.
module stm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       run,
    input logic       irq_en,
    input logic       lo_sys,
    input logic [1:0] xsel,
    input logic [7:0] rl_lo,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_hi,
    input logic       flag_lo,
    input logic       flag_hi,
    input logic       irq,
    input logic       adc_trig
);
    logic clr_lo_w, clr_hi_w;
    assign clr_lo_w = wr_en && (wr_addr == 2'd1) && wr_data[0];
    assign clr_hi_w = wr_en && (wr_addr == 2'd1) && wr_data[1];

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(cnt_lo) && $stable(cnt_hi)));
    a_r2_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lo_sys && cnt_lo != 8'hFF) |=> (cnt_lo == $past(cnt_lo) + 8'd1));
    a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_sys && xsel == 2'b11) |=> $stable(cnt_lo));
    a_r8_sticky_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_lo && !clr_lo_w) |=> flag_lo);
    a_r8_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_hi && !clr_hi_w) |=> flag_hi);
    a_r9_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_hi || flag_lo));
    a_r9_irq_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && flag_hi) |-> irq);
    a_r11_trig: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> (cnt_lo == rl_lo && flag_lo));
    a_r11_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_lo) |-> adc_trig);
endmodule

bind split_timer8x2 stm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .irq_en(irq_en), .lo_sys(lo_sys),
    .xsel(xsel), .rl_lo(rl_lo), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(irq), .adc_trig(adc_trig));

// File: tb/tb_split_timer8x2.sv
module tb_split_timer8x2;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_in = 1'b0, ext_clk_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] cnt_lo, cnt_hi;
    logic       flag_lo, flag_hi, irq, adc_trig;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    split_timer8x2 dut (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .ext_clk_in(ext_clk_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .flag_lo(flag_lo),
        .flag_hi(flag_hi), .irq(irq), .adc_trig(adc_trig));

    // {lo_fast, hi_fast, reload_lo, reload_hi, cycles}
    typedef struct packed {
        logic       lo_f;
        logic       hi_f;
        logic [7:0] rl_l;
        logic [7:0] rl_h;
        logic [15:0] n;
    } vec_t;
    localparam int NV = 5;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 8'h00, 8'h00, 16'd100},
        '{1'b0, 1'b1, 8'h00, 8'h00, 16'd300},
        '{1'b1, 1'b0, 8'hF0, 8'h00, 16'd300},
        '{1'b1, 1'b1, 8'h80, 8'h10, 16'd700},
        '{1'b0, 1'b0, 8'h00, 8'h00, 16'd50}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmp_in = 1'b0; ext_clk_in = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulses(input int n, input bit on_cmp, input bit on_ext);
        for (int i = 0; i < n; i++) begin
            cmp_in = on_cmp; ext_clk_in = on_ext;
            repeat (3) @(negedge clk);
            cmp_in = 1'b0; ext_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    function automatic int model(input int rl, input int t, output bit wrapped);
        int c = 0;
        wrapped = 0;
        for (int i = 0; i < t; i++) begin
            if (c == 255) begin c = rl; wrapped = 1; end
            else c++;
        end
        return c;
    endfunction

    initial begin
        #2000000;
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: state held in reset and right after release
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 cnt in reset", {cnt_hi, cnt_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags/irq/trig", {flag_lo, flag_hi, irq, adc_trig}, 0);

        // Table: R2 fast mode, R3 div-12 slow mode, R7 reload, R8 flags, R9 irq
        for (int v = 0; v < NV; v++) begin
            int tl, th, el, eh;
            bit wl, wh;
            do_reset();
            wr(2'd2, VT[v].rl_l);
            wr(2'd3, VT[v].rl_h);
            wr(2'd0, 8'h03 | (8'(VT[v].lo_f) << 3) | (8'(VT[v].hi_f) << 4));
            repeat (int'(VT[v].n)) @(negedge clk);
            tl = VT[v].lo_f ? int'(VT[v].n) : (int'(VT[v].n) + 3) / 12;
            th = VT[v].hi_f ? int'(VT[v].n) : (int'(VT[v].n) + 3) / 12;
            el = model(int'(VT[v].rl_l), tl, wl);
            eh = model(int'(VT[v].rl_h), th, wh);
            check("R2/R3/R7 cnt_lo", cnt_lo, el);
            check("R2/R3/R7 cnt_hi", cnt_hi, eh);
            check("R8 flag_lo", flag_lo, wl);
            check("R8 flag_hi", flag_hi, wh);
            check("R9 irq hi only", irq, wh);
        end

        // R4: comparator edges
        do_reset();
        wr(2'd0, 8'h21);
        pulses(5, 1'b1, 1'b0);
        check("R4 cmp lo", cnt_lo, 5);
        check("R4 cmp hi", cnt_hi, 5);

        // R5: external clock / 8
        do_reset();
        wr(2'd0, 8'h41);
        pulses(20, 1'b0, 1'b1);
        check("R5 ext8 lo", cnt_lo, 2);
        check("R5 ext8 hi", cnt_hi, 2);

        // R6: reserved select
        do_reset();
        wr(2'd0, 8'h61);
        pulses(20, 1'b1, 1'b1);
        check("R6 reserved", {cnt_hi, cnt_lo}, 0);

        // R10: run off holds
        do_reset();
        wr(2'd0, 8'h18);
        repeat (20) @(negedge clk);
        check("R10 stopped", {cnt_hi, cnt_lo}, 0);
        wr(2'd0, 8'h19);
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h18);
        repeat (10) @(negedge clk);
        check("R10 hold lo", cnt_lo, 5);
        check("R10 hold hi", cnt_hi, 5);

        // R11 / R7: trigger on low wrap
        do_reset();
        wr(2'd2, 8'h33);
        wr(2'd0, 8'h09);
        repeat (255) @(negedge clk);
        check("R11 before wrap cnt", cnt_lo, 255);
        check("R11 before wrap trig", adc_trig, 0);
        @(negedge clk);
        check("R7 reload value", cnt_lo, 8'h33);
        check("R11 trig", adc_trig, 1);
        check("R9 irq disabled", irq, 0);
        @(negedge clk);
        check("R11 trig one cycle", adc_trig, 0);
        wr(2'd0, 8'h0B);
        check("R9 low flag without low enable", irq, 0);
        wr(2'd0, 8'h0F);
        check("R9 low flag with low enable", irq, 1);
        wr(2'd0, 8'h0E);
        wr(2'd1, 8'h01);
        check("R8 cleared", flag_lo, 0);
        check("R9 irq after clear", irq, 0);

        // R8: set wins over clear (reload 0xFF wraps every cycle)
        do_reset();
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h09);
        repeat (260) @(negedge clk);
        check("R8 flag set", flag_lo, 1);
        wr(2'd1, 8'h01);
        check("R8 set beats clear", flag_lo, 1);
        check("R11 trig each wrap", adc_trig, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule